// File: doc/BRIEF.md
# Stack Push/Pop Sequencer

This block runs stack operations on behalf of an integer core. A start strobe hands it an operation code, an operand size (16 or 32 bits), an operand value and a destination register index. The block then walks the operation through a byte-addressed memory port, one word per beat with a ready handshake, and issues writes to an eight-entry register file. A single-cycle done pulse closes each operation.

The register file is held outside the block. Its current contents arrive on a flat input bus, and the block changes it only through its one write port. Register index 4 is the stack pointer and index 5 is the frame pointer. The block keeps a working copy of the stack pointer while a sequence runs. It writes the final stack pointer value back in the same cycle as the done pulse.

Operations are single push and pop, call and return, frame entry and frame exit, and the eight-register save and restore. Memory is little-endian: byte 0 of a word is stored at the lowest address.

Top module: `stack_seq`

## Requirements
- R1: Push (op code 0) first lowers the stack pointer by 4 (size32_i=1) or by 2 (size32_i=0), then writes the operand at the new stack pointer. Data is little-endian: mem_wdata_o bits [7:0] go to mem_addr_o, and a 32-bit push of 0x00000023 puts 0x23 at the lowest address.
- R2: Pop (op code 1) first reads at the stack pointer, then raises it by the operand size. The result goes to register dst_i. A 16-bit pop replaces only bits [15:0] of that register.
- R3: Call (op code 2) pushes operand_i as the return address. Return (op code 3) pops that address onto ret_addr_o, with ret_valid_o high in the done cycle. It then adds operand_i to the stack pointer, on top of the pop increment.
- R4: Enter (op code 4) pushes register 5, then copies the new stack pointer into register 5.
- R5: Leave (op code 5) loads the stack pointer from register 5, then pops register 5.
- R6: Save-all (op code 6) pushes registers 0, 1, 2, 3, then the stack pointer as it was before the operation, then registers 5, 6, 7, in that order.
- R7: Restore-all (op code 7) pops registers 7, 6, 5, then consumes the saved stack pointer slot without writing it, then pops 3, 2, 1, 0. The final stack pointer is the start value plus eight operand sizes.
- R8: A memory beat completes only when mem_req_o and mem_ready_i are both high. While ready is low, the request, address and direction hold steady. Each operation ends with exactly one done cycle, and that cycle carries the write of register 4.
- R9: A start strobe during a running operation is ignored. Registers that the operation does not name keep their values.
- R10: A pop whose destination is register 4 leaves the popped value in the stack pointer, with no increment applied.
- R11: After reset, no memory request, register write or done pulse is issued until a start strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| op_i | input | 3 | Operation code (see R1-R7 for values) |
| size32_i | input | 1 | 1 = 32-bit operand, 0 = 16-bit |
| operand_i | input | 32 | Push value, call return address or return adjustment |
| dst_i | input | 3 | Pop destination register index |
| regs_i | input | 256 | Register file contents, register k in bits [32k+31:32k] |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = write beat, 0 = read beat |
| mem_wide_o | output | 1 | 1 = 32-bit beat, 0 = 16-bit beat |
| mem_addr_o | output | 32 | Byte address of the lowest byte |
| mem_wdata_o | output | 32 | Write data, little-endian |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Beat accepted |
| rf_we_o | output | 1 | Register file write enable |
| rf_idx_o | output | 3 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| done_o | output | 1 | One-cycle completion pulse |
| ret_valid_o | output | 1 | Return address valid (return op, done cycle) |
| ret_addr_o | output | 32 | Popped return address |

## Verification
Some properties are checked by assertions on every cycle. These are the stable request during a stalled beat and the single-cycle done that carries the stack pointer write. They also cover the stack pointer only ever being written in the done cycle, which is what skipping the saved slot requires. The last group is the decrement-before-write and increment-after-read relations between each accepted address and the working stack pointer. The bench scenarios are the only evidence for data-level behaviour: byte order in memory, the fixed orders of save-all and restore-all, the compound steps of enter, leave and return, the 16-bit merge, a pop into the stack pointer, and a start strobe that is dropped because it arrives mid-sequence.

// File: rtl/sseq_pkg.sv
`timescale 1ns/1ps
package sseq_pkg;
  localparam int XLEN   = 32;
  localparam int HLEN   = XLEN / 2;
  localparam int NREG   = 8;
  localparam int RIDX_W = $clog2(NREG);
  localparam int SP_IDX = 4;
  localparam int FP_IDX = 5;

  typedef enum logic [2:0] {
    OP_PUSH    = 3'd0,
    OP_POP     = 3'd1,
    OP_CALL    = 3'd2,
    OP_RET     = 3'd3,
    OP_ENTER   = 3'd4,
    OP_LEAVE   = 3'd5,
    OP_PUSHALL = 3'd6,
    OP_POPALL  = 3'd7
  } op_e;

  typedef enum logic [1:0] {TG_NONE, TG_REG, TG_SP, TG_RET} tgt_e;

  // Bytes moved by one stack slot.
  function automatic logic [XLEN-1:0] slot_bytes(input logic wide);
    return wide ? XLEN'(XLEN/8) : XLEN'(HLEN/8);
  endfunction

  // A narrow load only replaces the low half of a register.
  function automatic logic [XLEN-1:0] merge_half(input logic [XLEN-1:0] old_v,
                                                 input logic [XLEN-1:0] new_v,
                                                 input logic wide);
    return wide ? new_v : {old_v[XLEN-1:HLEN], new_v[HLEN-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] zext_half(input logic [XLEN-1:0] v,
                                                input logic wide);
    return wide ? v : {{HLEN{1'b0}}, v[HLEN-1:0]};
  endfunction
endpackage

// File: rtl/sseq_sp_math.sv
`timescale 1ns/1ps
module sseq_sp_math
  import sseq_pkg::*;
(
  input  logic [XLEN-1:0] sp,
  input  logic            wide,
  input  logic            is_write,
  input  logic [XLEN-1:0] extra,
  output logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] sp_after
);
  logic [XLEN-1:0] dec_sp;
  assign dec_sp   = sp - slot_bytes(wide);
  assign addr     = is_write ? dec_sp : sp;
  assign sp_after = is_write ? dec_sp : sp + slot_bytes(wide) + extra;
endmodule

// File: rtl/sseq_beat_plan.sv
`timescale 1ns/1ps
module sseq_beat_plan
  import sseq_pkg::*;
(
  input  op_e                   op,
  input  logic [RIDX_W-1:0]     step,
  input  logic [NREG*XLEN-1:0]  regs,
  input  logic [XLEN-1:0]       sp_orig,
  input  logic [XLEN-1:0]       operand,
  input  logic [RIDX_W-1:0]     dst,
  output logic                  is_write,
  output logic                  last,
  output tgt_e                  tgt_kind,
  output logic [RIDX_W-1:0]     tgt_idx,
  output logic [XLEN-1:0]       wdata
);
  logic [XLEN-1:0] reg_a [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign reg_a[g] = regs[g*XLEN +: XLEN];
  end

  logic at_final;
  logic [RIDX_W-1:0] rev_idx;
  assign at_final = (step == RIDX_W'(NREG-1));
  assign rev_idx  = RIDX_W'(NREG-1) - step;

  always_comb begin
    is_write = 1'b0;
    last     = 1'b1;
    tgt_kind = TG_NONE;
    tgt_idx  = '0;
    wdata    = '0;
    unique case (op)
      OP_PUSH, OP_CALL: begin
        is_write = 1'b1;
        wdata    = operand;
      end
      OP_ENTER: begin
        is_write = 1'b1;
        wdata    = reg_a[FP_IDX];
      end
      OP_PUSHALL: begin
        is_write = 1'b1;
        last     = at_final;
        wdata    = (step == RIDX_W'(SP_IDX)) ? sp_orig : reg_a[step];
      end
      OP_POP: begin
        tgt_idx  = dst;
        tgt_kind = (dst == RIDX_W'(SP_IDX)) ? TG_SP : TG_REG;
      end
      OP_RET:   tgt_kind = TG_RET;
      OP_LEAVE: begin
        tgt_idx  = RIDX_W'(FP_IDX);
        tgt_kind = TG_REG;
      end
      OP_POPALL: begin
        last     = at_final;
        tgt_idx  = rev_idx;
        tgt_kind = (rev_idx == RIDX_W'(SP_IDX)) ? TG_NONE : TG_REG;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stack_seq.sv
`timescale 1ns/1ps
module stack_seq
  import sseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [2:0]            op_i,
  input  logic                  size32_i,
  input  logic [XLEN-1:0]       operand_i,
  input  logic [RIDX_W-1:0]     dst_i,
  input  logic [NREG*XLEN-1:0]  regs_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic                  mem_wide_o,
  output logic [XLEN-1:0]       mem_addr_o,
  output logic [XLEN-1:0]       mem_wdata_o,
  input  logic [XLEN-1:0]       mem_rdata_i,
  input  logic                  mem_ready_i,
  output logic                  rf_we_o,
  output logic [RIDX_W-1:0]     rf_idx_o,
  output logic [XLEN-1:0]       rf_wdata_o,
  output logic                  done_o,
  output logic                  ret_valid_o,
  output logic [XLEN-1:0]       ret_addr_o
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FRAME, S_FIN} state_e;

  state_e            state;
  op_e               op_q;
  logic              wide_q;
  logic [XLEN-1:0]   opnd_q, sp_q, sp_orig_q, ret_addr_q, rf_wdata_q;
  logic [RIDX_W-1:0] dst_q, step_q, rf_idx_q;
  logic              rf_we_q, done_q, ret_valid_q;

  logic [XLEN-1:0] reg_a [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign reg_a[g] = regs_i[g*XLEN +: XLEN];
  end

  // Named internal events
  logic              beat_ack, is_write, last;
  tgt_e              tgt_kind;
  logic [RIDX_W-1:0] tgt_idx;
  logic [XLEN-1:0]   wdata, beat_addr, sp_after, ret_extra, load_val;

  assign beat_ack  = mem_req_o && mem_ready_i;
  assign ret_extra = (op_q == OP_RET) ? opnd_q : '0;
  assign load_val  = merge_half(reg_a[tgt_idx], mem_rdata_i, wide_q);

  sseq_beat_plan u_plan (
    .op(op_q), .step(step_q), .regs(regs_i), .sp_orig(sp_orig_q),
    .operand(opnd_q), .dst(dst_q), .is_write(is_write), .last(last),
    .tgt_kind(tgt_kind), .tgt_idx(tgt_idx), .wdata(wdata)
  );

  sseq_sp_math u_math (
    .sp(sp_q), .wide(wide_q), .is_write(is_write), .extra(ret_extra),
    .addr(beat_addr), .sp_after(sp_after)
  );

  assign mem_req_o   = (state == S_XFER);
  assign mem_we_o    = mem_req_o && is_write;
  assign mem_wide_o  = wide_q;
  assign mem_addr_o  = beat_addr;
  assign mem_wdata_o = wdata;
  assign rf_we_o     = rf_we_q;
  assign rf_idx_o    = rf_idx_q;
  assign rf_wdata_o  = rf_wdata_q;
  assign done_o      = done_q;
  assign ret_valid_o = ret_valid_q;
  assign ret_addr_o  = ret_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      op_q        <= OP_PUSH;
      wide_q      <= 1'b1;
      opnd_q      <= '0;
      dst_q       <= '0;
      sp_q        <= '0;
      sp_orig_q   <= '0;
      step_q      <= '0;
      rf_we_q     <= 1'b0;
      rf_idx_q    <= '0;
      rf_wdata_q  <= '0;
      done_q      <= 1'b0;
      ret_valid_q <= 1'b0;
      ret_addr_q  <= '0;
    end else begin
      rf_we_q     <= 1'b0;
      done_q      <= 1'b0;
      ret_valid_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) begin
          op_q      <= op_e'(op_i);
          wide_q    <= size32_i;
          opnd_q    <= operand_i;
          dst_q     <= dst_i;
          sp_orig_q <= reg_a[SP_IDX];
          sp_q      <= (op_e'(op_i) == OP_LEAVE) ? reg_a[FP_IDX] : reg_a[SP_IDX];
          step_q    <= '0;
          state     <= S_XFER;
        end
        S_XFER: if (beat_ack) begin
          step_q <= step_q + 1'b1;
          sp_q   <= sp_after;
          if (!is_write) begin
            unique case (tgt_kind)
              TG_REG: begin
                rf_we_q    <= 1'b1;
                rf_idx_q   <= tgt_idx;
                rf_wdata_q <= load_val;
              end
              TG_SP:   sp_q       <= load_val;
              TG_RET:  ret_addr_q <= zext_half(mem_rdata_i, wide_q);
              default: ;
            endcase
          end
          if (last) state <= (op_q == OP_ENTER) ? S_FRAME : S_FIN;
        end
        S_FRAME: begin
          rf_we_q    <= 1'b1;
          rf_idx_q   <= RIDX_W'(FP_IDX);
          rf_wdata_q <= sp_q;
          state      <= S_FIN;
        end
        S_FIN: begin
          rf_we_q     <= 1'b1;
          rf_idx_q    <= RIDX_W'(SP_IDX);
          rf_wdata_q  <= sp_q;
          done_q      <= 1'b1;
          ret_valid_q <= (op_q == OP_RET);
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_predec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ack && mem_we_o) |=> (sp_q == $past(mem_addr_o)));

  p_postinc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ack && !mem_we_o && op_q == OP_POP && dst_q != RIDX_W'(SP_IDX))
      |=> (sp_q == $past(mem_addr_o) + slot_bytes(wide_q)));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i)
      |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_spwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rf_we_o && rf_idx_o == RIDX_W'(SP_IDX)));

  p_sp_only_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && rf_idx_o == RIDX_W'(SP_IDX)) |-> done_o);

  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && start_i) |=> $stable(op_q));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !mem_req_o);
endmodule

// File: tb/test_stack_seq.sv
`timescale 1ns/1ps
module test_stack_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        wide = 1'b1;
  logic [31:0] opnd = '0;
  logic [2:0]  dst = '0;
  logic [255:0] regs_flat;
  logic        mem_req, mem_we, mem_wide, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rf_we, done, ret_valid;
  logic [2:0]  rf_idx;
  logic [31:0] rf_wdata, ret_addr;

  stack_seq i_stack_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .size32_i(wide),
    .operand_i(opnd), .dst_i(dst), .regs_i(regs_flat),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .rf_we_o(rf_we), .rf_idx_o(rf_idx),
    .rf_wdata_o(rf_wdata), .done_o(done), .ret_valid_o(ret_valid),
    .ret_addr_o(ret_addr)
  );

  // ---------- models (single writer process) ----------
  logic [7:0]  mem_m [1024];
  logic [31:0] regs_m [8];
  int          hold_cycles = 0;
  int          held;
  logic        poke_r_en = 1'b0, poke_m_en = 1'b0;
  logic [2:0]  poke_r_idx = '0;
  logic [31:0] poke_r_val = '0, poke_m_val = '0;
  logic [9:0]  poke_m_addr = '0, ra;

  always_comb for (int i = 0; i < 8; i++) regs_flat[i*32 +: 32] = regs_m[i];
  always_comb begin
    ra = mem_addr[9:0];
    mem_rdata = {mem_m[ra+10'd3], mem_m[ra+10'd2], mem_m[ra+10'd1], mem_m[ra]};
  end
  assign mem_ready = (held >= hold_cycles);

  initial begin
    held = 0;
    for (int i = 0; i < 1024; i++) mem_m[i] = 8'h00;
    for (int i = 0; i < 8; i++) regs_m[i] = 32'h0;
  end

  always @(posedge clk) begin
    if (poke_r_en) regs_m[poke_r_idx] <= poke_r_val;
    else if (rf_we) regs_m[rf_idx] <= rf_wdata;
    if (poke_m_en) begin
      for (int b = 0; b < 4; b++) mem_m[poke_m_addr + 10'(b)] <= poke_m_val[b*8 +: 8];
    end else if (mem_req && mem_ready && mem_we) begin
      for (int b = 0; b < (mem_wide ? 4 : 2); b++)
        mem_m[mem_addr[9:0] + 10'(b)] <= mem_wdata[b*8 +: 8];
    end
    if (mem_req && !mem_ready) held <= held + 1; else held <= 0;
  end

  // ---------- bookkeeping ----------
  int checks = 0, errors = 0;
  int dones;
  logic got_rv;
  logic [31:0] got_ra;
  logic [31:0] snap [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] peek32(input logic [9:0] a);
    return {mem_m[a+10'd3], mem_m[a+10'd2], mem_m[a+10'd1], mem_m[a]};
  endfunction

  task automatic set_reg(input int idx, input logic [31:0] v);
    @(negedge clk); poke_r_en = 1'b1; poke_r_idx = 3'(idx); poke_r_val = v;
    @(negedge clk); poke_r_en = 1'b0;
  endtask

  task automatic set_mem(input logic [9:0] a, input logic [31:0] v);
    @(negedge clk); poke_m_en = 1'b1; poke_m_addr = a; poke_m_val = v;
    @(negedge clk); poke_m_en = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] o, input logic w, input logic [31:0] v,
                        input logic [2:0] d, input logic busy_start);
    int cyc;
    logic got;
    dones = 0; got = 1'b0; cyc = 0; got_rv = 1'b0; got_ra = '0;
    @(negedge clk); op = o; wide = w; opnd = v; dst = d; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!got && cyc < 400) begin
      if (busy_start && cyc == 1) begin op = 3'd1; dst = 3'd1; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (done) begin got = 1'b1; dones++; got_rv = ret_valid; got_ra = ret_addr; end
    end
    start = 1'b0;
    if (!got) begin errors++; $display("FAIL R8 no done: actual=0 expected=1"); end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) dones++;
      if (mem_req) begin errors++; $display("FAIL R9 request after done: actual=1 expected=0"); end
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic        w;
    logic [31:0] v;
    logic [2:0]  d;
    logic [31:0] sp;
    logic [1:0]  kind;   // 0 mem32 at sp, 1 mem16 at sp, 2 register d
    logic [31:0] val;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 1'b1, 32'h00000023, 3'd0, 32'h1FC, 2'd0, 32'h00000023},
    '{3'd0, 1'b1, 32'hA1B2C3D4, 3'd0, 32'h1F8, 2'd0, 32'hA1B2C3D4},
    '{3'd0, 1'b0, 32'h00001234, 3'd0, 32'h1F6, 2'd1, 32'h00001234},
    '{3'd1, 1'b0, 32'h0,        3'd2, 32'h1F8, 2'd2, 32'h33331234},
    '{3'd1, 1'b1, 32'h0,        3'd3, 32'h1FC, 2'd2, 32'hA1B2C3D4},
    '{3'd1, 1'b1, 32'h0,        3'd0, 32'h200, 2'd2, 32'h00000023}
  };

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_reg(0, 32'h11111111); set_reg(1, 32'h22222222);
    set_reg(2, 32'h33333333); set_reg(3, 32'h44444444);
    set_reg(4, 32'h00000200); set_reg(5, 32'h66666666);
    set_reg(6, 32'h77777777); set_reg(7, 32'h88888888);
    // R11 reset state
    chk("R11 req in reset", {31'b0, mem_req}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 req after reset", {31'b0, mem_req}, 0);
    chk("R11 done after reset", {31'b0, done}, 0);
    chk("R11 rf write after reset", {31'b0, rf_we}, 0);

    // R1/R2 vector table
    foreach (VECS[i]) begin
      run_op(VECS[i].op, VECS[i].w, VECS[i].v, VECS[i].d, 1'b0);
      chk($sformatf("R8 done count vec%0d", i), dones, 1);
      chk($sformatf("R1/R2 sp vec%0d", i), regs_m[4], VECS[i].sp);
      case (VECS[i].kind)
        2'd0: chk($sformatf("R1 mem32 vec%0d", i), peek32(VECS[i].sp[9:0]), VECS[i].val);
        2'd1: chk($sformatf("R1 mem16 vec%0d", i), {16'h0, peek32(VECS[i].sp[9:0]) & 32'hFFFF} & 32'hFFFF, VECS[i].val);
        default: chk($sformatf("R2 reg vec%0d", i), regs_m[VECS[i].d], VECS[i].val);
      endcase
    end
    chk("R1 lowest byte", {24'h0, mem_m[10'h1FC]}, 32'h23);
    chk("R1 highest byte", {24'h0, mem_m[10'h1FF]}, 32'h00);
    chk("R1 byte order low", {24'h0, mem_m[10'h1F8]}, 32'hD4);
    chk("R1 byte order high", {24'h0, mem_m[10'h1FB]}, 32'hA1);

    // R3 call / return
    run_op(3'd2, 1'b1, 32'h40001000, 3'd0, 1'b0);
    chk("R3 call sp", regs_m[4], 32'h1FC);
    chk("R3 call pushed", peek32(10'h1FC), 32'h40001000);
    run_op(3'd3, 1'b1, 32'h8, 3'd0, 1'b0);
    chk("R3 ret valid", {31'b0, got_rv}, 1);
    chk("R3 ret addr", got_ra, 32'h40001000);
    chk("R3 ret sp", regs_m[4], 32'h208);
    set_reg(4, 32'h200);

    // R4 enter
    run_op(3'd4, 1'b1, 32'h0, 3'd0, 1'b0);
    chk("R4 saved fp", peek32(10'h1FC), 32'h66666666);
    chk("R4 sp", regs_m[4], 32'h1FC);
    chk("R4 fp", regs_m[5], 32'h1FC);

    // R5 leave
    set_reg(4, 32'h1F0);
    run_op(3'd5, 1'b1, 32'h0, 3'd0, 1'b0);
    chk("R5 sp", regs_m[4], 32'h200);
    chk("R5 fp", regs_m[5], 32'h66666666);

    // R6 save-all
    for (int k = 0; k < 8; k++) snap[k] = regs_m[k];
    run_op(3'd6, 1'b1, 32'h0, 3'd0, 1'b0);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R6 slot%0d", k), peek32(10'(32'h200 - 4*(k+1))), snap[k]);
    chk("R6 sp", regs_m[4], 32'h1E0);
    chk("R8 save-all done count", dones, 1);

    // R7 restore-all
    for (int k = 0; k < 8; k++) if (k != 4) set_reg(k, 32'hDEAD0000 + k);
    set_mem(10'h1EC, 32'hBADBAD00);
    run_op(3'd7, 1'b1, 32'h0, 3'd0, 1'b0);
    for (int k = 0; k < 8; k++)
      if (k != 4) chk($sformatf("R7 reg%0d", k), regs_m[k], snap[k]);
    chk("R7 sp skip slot", regs_m[4], 32'h200);

    // R10 pop into stack pointer
    run_op(3'd0, 1'b1, 32'h00000300, 3'd0, 1'b0);
    run_op(3'd1, 1'b1, 32'h0, 3'd4, 1'b0);
    chk("R10 sp from pop", regs_m[4], 32'h300);
    set_reg(4, 32'h200);

    // R9 / R8 stalled push with stray start
    for (int k = 0; k < 8; k++) snap[k] = regs_m[k];
    hold_cycles = 5;
    run_op(3'd0, 1'b1, 32'hCAFEF00D, 3'd0, 1'b1);
    hold_cycles = 0;
    chk("R9 single done", dones, 1);
    chk("R8 stalled push data", peek32(10'h1FC), 32'hCAFEF00D);
    chk("R9 sp", regs_m[4], 32'h1FC);
    for (int k = 0; k < 8; k++)
      if (k != 4) chk($sformatf("R9 reg%0d unchanged", k), regs_m[k], snap[k]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule